// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Interrupt Styles

This block controls sixteen general-purpose pins from a small word-addressed register interface. Software sets an output value and a direction for each pin. It reads the pin levels after synchronisation. For every line it picks one of five interrupt styles: two levels, two single edges, or any change. A detected event sets a sticky status bit, and software clears it by writing a one to that bit.

Lines 0 to 12 each drive their own active-high request output. A single combined request is high whenever any of the sixteen status bits is set. Two small counters can generate divided clocks, and control bits can route these clocks onto pins 14 and 15 in place of the programmed output value.

Top module: `gpio16_irq_ctrl`

## Requirements
- R1: After reset the direction register reads 0x0000FFFF and every output enable is low. The output data, status, both style registers, clock control and spare registers read 0. All request outputs are low.
- R2: Word address 0 is output data (bits 15:0), 1 is direction, 2 is the read-only input value, 3 is interrupt status, 4 holds the styles of lines 0-7, 5 holds the styles of lines 8-15, 6 is clock control and 7 is a spare read/write word. Unused bits read 0, writes to address 2 are ignored, and read data is combinational on the address.
- R3: A direction bit of 1 turns the pin's output enable off, and a 0 turns it on. `pin_out` carries the output data bits on every line that is not routed to a clock.
- R4: Each pin passes through two flops. A change applied before clock edge 1 is readable at address 2 after edge 2 and not after edge 1.
- R5: Style code 0 sets status while the synchronised pin is high, and code 1 sets it while the pin is low. A pin change applied before edge 1 sets status at edge 3 and not earlier.
- R6: Style code 2 sets status on a rising edge, code 3 on a falling edge and code 4 on either edge of the synchronised pin.
- R7: Style codes 5, 6 and 7 never set the status bit.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A detection in the same cycle as the clear leaves the bit set.
- R9: A status bit set by an edge style stays set until it is cleared. A level-style bit that is cleared while the pin is still active reads 1 again straight after the clearing write.
- R10: `line_irq[n]` equals status bit n for n from 0 to 12. `irq_any` is the OR of all sixteen status bits.
- R11: Clock control bit 8 puts generated clock 0 on `pin_out[14]` and forces `pin_oe[14]` high. Bit 24 does the same with clock 1 on pin 15. Clock 0 takes its low threshold from bits 3:0 and its terminal count from bits 7:4, and clock 1 takes them from bits 19:16 and 23:20. A clock with terminal count T and threshold D has a period of T+1 cycles and is high for min(D,T)+1 of them. Clearing the routing bit returns the pin to the output data bit.
- R12: Line n uses style bits [3k+2:3k] with k = n mod 8. The bits are in the address 4 register for n < 8 and in the address 5 register otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | Write when high during an access |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| pin_in | input | 16 | Pin levels, asynchronous |
| pin_out | output | 16 | Values to drive onto the pins |
| pin_oe | output | 16 | Output enables, high drives the pin |
| line_irq | output | 13 | Per-line active-high requests for lines 0-12 |
| irq_any | output | 1 | Combined request |

## Verification
The hardest case to reach is a status clear that falls in the same cycle as a new detection, and the correct behaviour here differs between level and edge lines. The random phase reaches it by giving every line a fresh random style code, reserved codes included, and then clearing all status while the pins hold steady. In that cycle level lines detect again and edge lines do not. Each random pin step is held for four cycles, so the expected status can be built from the old and new pin words alone. Directed cases pin down the exact cycle of the synchroniser delay and the duty cycle of each generated clock, which the bench measures by counting high samples over whole periods.

// File: rtl/gpio16_irq_ctrl.sv
module gpio16_irq_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [15:0] pin_in,
  output logic [15:0] pin_out,
  output logic [15:0] pin_oe,
  output logic [12:0] line_irq,
  output logic        irq_any
);
  localparam logic [31:0] CCTL_MASK = 32'h01FF_01FF;

  logic [15:0] dout_q, dir_q, stat_q, sync1, sync2, prev_q;
  logic [23:0] sty_lo, sty_hi;
  logic [31:0] cctl_q, spare_q;
  logic [15:0] hit, edge_mask, rsv_mask, clr_vec;
  logic [1:0]  gclk;
  logic        wr;

  assign wr      = bus_sel & bus_wr;
  assign clr_vec = (wr && bus_addr == 3'd3) ? bus_wdata[15:0] : 16'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      dir_q   <= '1;
      sty_lo  <= '0;
      sty_hi  <= '0;
      cctl_q  <= '0;
      spare_q <= '0;
    end else if (wr) begin
      case (bus_addr)
        3'd0: dout_q  <= bus_wdata[15:0];
        3'd1: dir_q   <= bus_wdata[15:0];
        3'd4: sty_lo  <= bus_wdata[23:0];
        3'd5: sty_hi  <= bus_wdata[23:0];
        3'd6: cctl_q  <= bus_wdata & CCTL_MASK;
        3'd7: spare_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      sync1  <= pin_in;
      sync2  <= sync1;
      prev_q <= sync2;
      stat_q <= (stat_q & ~clr_vec) | hit;
    end
  end

  for (genvar i = 0; i < 16; i++) begin : g_line
    logic [2:0] code;
    assign code = (i < 8) ? sty_lo[3*(i%8) +: 3] : sty_hi[3*(i%8) +: 3];
    always_comb begin
      case (code)
        3'd0:    hit[i] = sync2[i];
        3'd1:    hit[i] = ~sync2[i];
        3'd2:    hit[i] = sync2[i] & ~prev_q[i];
        3'd3:    hit[i] = ~sync2[i] & prev_q[i];
        3'd4:    hit[i] = sync2[i] ^ prev_q[i];
        default: hit[i] = 1'b0;
      endcase
    end
    assign edge_mask[i] = (code == 3'd2) || (code == 3'd3) || (code == 3'd4);
    assign rsv_mask[i]  = code > 3'd4;
  end

  for (genvar g = 0; g < 2; g++) begin : g_clk
    logic [3:0] cnt;
    logic [3:0] dc, tc;
    assign dc = cctl_q[16*g +: 4];
    assign tc = cctl_q[16*g+4 +: 4];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (cnt >= tc) cnt <= '0;
      else                cnt <= cnt + 4'd1;
    end
    assign gclk[g] = (cnt <= dc);
  end

  assign pin_out = {cctl_q[24] ? gclk[1] : dout_q[15],
                    cctl_q[8]  ? gclk[0] : dout_q[14],
                    dout_q[13:0]};
  assign pin_oe  = {~dir_q[15] | cctl_q[24], ~dir_q[14] | cctl_q[8], ~dir_q[13:0]};
  assign line_irq = stat_q[12:0];
  assign irq_any  = |stat_q;

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {16'h0, dout_q};
      3'd1:    bus_rdata = {16'h0, dir_q};
      3'd2:    bus_rdata = {16'h0, sync2};
      3'd3:    bus_rdata = {16'h0, stat_q};
      3'd4:    bus_rdata = {8'h0, sty_lo};
      3'd5:    bus_rdata = {8'h0, sty_hi};
      3'd6:    bus_rdata = cctl_q;
      default: bus_rdata = spare_q;
    endcase
  end

  assert_oe_follows_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 3'd1) |=> (pin_oe[13:0] == ~$past(bus_wdata[13:0])));

  assert_clear_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == 3'd3) |=> ((stat_q & $past(bus_wdata[15:0]) & ~$past(hit)) == 16'h0));

  assert_reserved_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & $past(rsv_mask)) == 16'h0));

  assert_edge_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q & edge_mask & ~clr_vec) & ~stat_q) == 16'h0));

  assert_input_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sync2 == $past(sync1)));
endmodule

// File: tb/gpio16_irq_ctrl_tb.sv
module gpio16_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic [12:0] line_irq;
  logic        irq_any;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio16_irq_ctrl u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] all_codes(logic [2:0] c);
    logic [23:0] r = '0;
    for (int k = 0; k < 8; k++) r[3*k +: 3] = c;
    return r;
  endfunction

  function automatic logic hit_f(logic [2:0] c, logic nw, logic od);
    case (c)
      3'd0: return nw;
      3'd1: return ~nw;
      3'd2: return nw & ~od;
      3'd3: return ~nw & od;
      3'd4: return nw ^ od;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] hits(logic [47:0] st, logic [15:0] nw, logic [15:0] od);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = hit_f(st[3*i +: 3], nw[i], od[i]);
    return r;
  endfunction

  task automatic count_high(int bit_i, int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pin_out[bit_i]) hi++;
    end
  endtask

  initial begin
    logic [31:0] d;
    logic [47:0] st;
    logic [15:0] exp_s, old_p, new_p;
    int hi;
    void'($urandom(32'd1234));
    waitn(2);
    rst_n = 1;
    waitn(1);
    // R1 reset state
    rd(3'd1, d); chk("R1 dir", d, 32'h0000FFFF);
    chk("R1 oe", pin_oe, 0);
    rd(3'd3, d); chk("R1 status", d, 0);
    rd(3'd4, d); chk("R1 style lo", d, 0);
    rd(3'd5, d); chk("R1 style hi", d, 0);
    rd(3'd6, d); chk("R1 clkctl", d, 0);
    rd(3'd0, d); chk("R1 dout", d, 0);
    chk("R1 irqs", {irq_any, line_irq}, 0);
    // R2 map
    wr(3'd0, 32'h1234A5A5); rd(3'd0, d); chk("R2 dout width", d, 32'h0000A5A5);
    wr(3'd7, 32'hDEADBEEF); rd(3'd7, d); chk("R2 spare", d, 32'hDEADBEEF);
    wr(3'd2, 32'hFFFFFFFF); rd(3'd2, d); chk("R2 input read-only", d, 0);
    wr(3'd6, 32'hFFFFFFFF); rd(3'd6, d); chk("R2 clkctl mask", d, 32'h01FF01FF);
    wr(3'd6, 0);
    // R3 direction
    wr(3'd1, 32'h00FF);
    chk("R3 oe", pin_oe, 16'hFF00);
    chk("R3 pin_out", pin_out, 16'hA5A5);
    wr(3'd1, 32'hFFFF);
    chk("R3 all inputs", pin_oe, 0);
    // R4 synchroniser
    pin_in = 16'h5A3C;
    waitn(1); rd(3'd2, d); chk("R4 after one edge", d, 0);
    waitn(1); rd(3'd2, d); chk("R4 after two edges", d, 32'h5A3C);
    // R5 level-high timing on line 0, others reserved
    wr(3'd4, all_codes(3'd5) & ~24'h7); wr(3'd5, all_codes(3'd5));
    pin_in = 0; waitn(3); wr(3'd3, 32'hFFFF);
    rd(3'd3, d); chk("R5 cleared", d, 0);
    pin_in = 16'h0001;
    waitn(2); rd(3'd3, d); chk("R5 not before edge 3", d, 0);
    waitn(1); rd(3'd3, d); chk("R5 set at edge 3", d, 1);
    chk("R10 line0 irq", {irq_any, line_irq}, {1'b1, 13'h1});
    // R9 level re-set, R8 zero write
    wr(3'd3, 32'h0001); rd(3'd3, d); chk("R9 level re-set", d, 1);
    wr(3'd3, 32'h0000); rd(3'd3, d); chk("R8 zero write", d, 1);
    pin_in = 0; waitn(3); wr(3'd3, 32'h0001);
    rd(3'd3, d); chk("R8 clear", d, 0);
    // R6/R9 rising sticky on line 0
    wr(3'd4, all_codes(3'd5) & ~24'h7 | 24'h2);
    pin_in = 1; waitn(3); rd(3'd3, d); chk("R6 rising", d, 1);
    pin_in = 0; waitn(4); rd(3'd3, d); chk("R9 edge sticky", d, 1);
    wr(3'd3, 32'h1); rd(3'd3, d); chk("R8 edge clear", d, 0);
    // R7 reserved codes
    wr(3'd4, all_codes(3'd6)); wr(3'd5, all_codes(3'd7));
    pin_in = 16'hFFFF; waitn(4); pin_in = 0; waitn(4);
    rd(3'd3, d); chk("R7 reserved", d, 0);
    // R12 field of line 13 (k=5, bits 17:15), falling; R10 no line irq
    wr(3'd5, (all_codes(3'd5) & ~(24'h7 << 15)) | (24'h3 << 15));
    pin_in = 16'h2000; waitn(4); rd(3'd3, d); chk("R12 no rise", d, 0);
    pin_in = 0; waitn(4); rd(3'd3, d); chk("R12 falling line13", d, 32'h2000);
    chk("R10 line13 combined only", {irq_any, line_irq}, {1'b1, 13'h0});
    wr(3'd3, 32'hFFFF);
    // R11 clocks
    wr(3'd1, 32'hFFFF); wr(3'd0, 32'h0);
    wr(3'd6, 32'h0000_0131);
    chk("R11 oe forced", pin_oe, 16'h4000);
    count_high(14, 40, hi); chk("R11 clk0 duty", hi, 20);
    wr(3'd6, 32'h0144_0000);
    count_high(15, 25, hi); chk("R11 clk1 saturated", hi, 25);
    wr(3'd6, 32'h0120_0000);
    count_high(15, 30, hi); chk("R11 clk1 1-of-3", hi, 10);
    wr(3'd0, 32'h8000); wr(3'd6, 0);
    chk("R11 released", {pin_oe, pin_out}, {16'h0, 16'h8000});
    // random: R5 R6 R7 R8 R9 R10
    old_p = 0; pin_in = 0; waitn(3);
    for (int it = 0; it < 60; it++) begin
      st = {$urandom(), $urandom()};
      wr(3'd4, st[23:0]); wr(3'd5, st[47:24]);
      wr(3'd3, 32'hFFFF);
      exp_s = hits(st, old_p, old_p);
      rd(3'd3, d); chk("R8 random clear", d, exp_s);
      new_p = $urandom();
      pin_in = new_p; waitn(4);
      exp_s |= hits(st, new_p, old_p);
      rd(3'd3, d); chk("R6 random status", d, exp_s);
      chk("R10 random irqs", {irq_any, line_irq}, {|exp_s, exp_s[12:0]});
      old_p = new_p;
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule